// File: doc/BRIEF.md
# Flag-Offset Register Bank

This block holds the two thresholds that drive the programmable almost-empty and almost-full flags of a synchronous FIFO. The empty threshold n and the full threshold m are each split over a low register and a high register. That makes four 8-bit-or-narrower registers, all reached through the FIFO's ordinary 9-bit data input and data output. While the load strobe `ld_n` is low, each write access on the write clock stores the input word into the currently selected register. Each read access on the read clock copies the selected register onto `dout`. After either kind of access the selection moves to the next register.

The selection is a state machine with four states, visited in a fixed order: SEL_EMPTY_LO, SEL_EMPTY_HI, SEL_FULL_LO, SEL_FULL_HI. There is one transition, ADVANCE, taken on every access. It goes from each state to the next, and from SEL_FULL_HI back to SEL_EMPTY_LO (WRAP). Raising `ld_n` does not move the selection, so a later load or readback picks up where the previous one stopped. Reset applies one more transition, RESET, which enters SEL_EMPTY_LO from any state. The state is formed from two 2-bit step counters, one in each clock domain, and is their sum modulo four. Loading and reading back at the same time is not supported, and the result in that case is undefined.

Top module: `ofs_bank`

## Requirements
- R1: Four offset registers are selected in the fixed cyclic order empty-low (state 0), empty-high (1), full-low (2), full-high (3). Both loading and readback follow this order.
- R2: On a rising `wr_clk` with `ld_n` low and `wen_n` low, the selected register takes `din`, and the selection advances by one.
- R3: On a rising `wr_clk` with `ld_n` low and `wen_n` high, or with `ld_n` high at any `wen_n`, no offset register changes and the selection holds. With `ld_n` high and `wen_n` low the cycle is an ordinary FIFO write, which leaves the offsets alone.
- R4: On a rising `rd_clk` with `ld_n`, `ren_a_n` and `ren_b_n` all low, `dout` takes the selected register zero-extended to 9 bits, and the selection advances. At all other times `dout` holds its value, including when only one read enable is low.
- R5: Raising `ld_n` keeps the selection in place, so a partial load or readback resumes at the register after the last one accessed.
- R6: Reset (`rst_n` low, asynchronous) sets both low registers to 007h, both high registers to 000h (n = m = 7), `dout` to 000h and the selection to empty-low.
- R7: An access in state full-high wraps the selection to empty-low.
- R8: A low register supplies offset bits 7:0 from `din[7:0]`, and a high register supplies offset bits 13:8 from `din[5:0]`. Any `din` bits above these are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; loads the registers |
| rd_clk | input | 1 | Read clock; reads back the registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Offset-access strobe, active low |
| wen_n | input | 1 | Write enable, active low |
| ren_a_n | input | 1 | First read enable, active low |
| ren_b_n | input | 1 | Second read enable, active low |
| din | input | 9 | FIFO data input word |
| dout | output | 9 | Readback word |
| empty_ofs | output | 14 | Assembled empty offset n |
| full_ofs | output | 14 | Assembled full offset m |

## Verification
Some properties can be checked on every clock edge, and the assertions cover these. A load places the input word into the selected register. Cycles that are not loads leave the registers and the write-side step count unchanged. `dout` keeps its value when no read access occurs. An access in the full-high state is followed by the empty-low state. Other behaviours depend on a history of accesses and can only be shown by the bench's scenarios. These are the resume point after partial loads and readbacks, the interleaving of write-side and read-side steps in the one shared order, the truncation of wide input words, and the return to empty-low after a reset in the middle of a sequence.

// File: rtl/ofs_bank_pkg.sv
package ofs_bank_pkg;

    // Selection state: the order is part of the behaviour (R1)
    typedef enum logic [1:0] {
        SEL_EMPTY_LO = 2'd0,
        SEL_EMPTY_HI = 2'd1,
        SEL_FULL_LO  = 2'd2,
        SEL_FULL_HI  = 2'd3
    } sel_e;

    localparam int NUM_OFFSETS = 2;

endpackage

// File: rtl/ofs_load_port.sv
module ofs_load_port
    import ofs_bank_pkg::*;
#(
    parameter int               DATA_W   = 9,
    parameter int               LO_W     = 8,
    parameter int               HI_W     = 6,
    parameter logic [LO_W-1:0]  LO_RESET = 'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] din,
    input  sel_e              sel,
    output logic [1:0]        steps,
    output logic [LO_W-1:0]   lo_q [NUM_OFFSETS],
    output logic [HI_W-1:0]   hi_q [NUM_OFFSETS]
);

    logic load_acc;
    assign load_acc = !ld_n && !wen_n;

    // Write-side share of the selection state (ADVANCE / RESET)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps <= 2'd0;
        end else if (load_acc) begin
            steps <= steps + 2'd1;
        end
    end

    // One low/high register pair per offset
    for (genvar g = 0; g < NUM_OFFSETS; g++) begin : g_pair
        logic hit;
        assign hit = load_acc && (sel[1] == 1'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[g] <= LO_RESET;
                hi_q[g] <= '0;
            end else if (hit) begin
                if (!sel[0]) begin
                    lo_q[g] <= din[LO_W-1:0];
                end else begin
                    hi_q[g] <= din[HI_W-1:0];
                end
            end
        end
    end

    AST_LOAD_EMPTY_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (load_acc && sel == SEL_EMPTY_LO) |=> lo_q[0] == $past(din[LO_W-1:0])); // R2
    AST_LOAD_FULL_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (load_acc && sel == SEL_FULL_HI) |=> hi_q[1] == $past(din[HI_W-1:0])); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_acc |=> ($stable(lo_q[0]) && $stable(hi_q[0]) &&
                       $stable(lo_q[1]) && $stable(hi_q[1]) && $stable(steps))); // R3

endmodule

// File: rtl/ofs_read_port.sv
module ofs_read_port
    import ofs_bank_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int LO_W   = 8,
    parameter int HI_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              ren_a_n,
    input  logic              ren_b_n,
    input  sel_e              sel,
    input  logic [LO_W-1:0]   empty_lo,
    input  logic [HI_W-1:0]   empty_hi,
    input  logic [LO_W-1:0]   full_lo,
    input  logic [HI_W-1:0]   full_hi,
    output logic [1:0]        steps,
    output logic [DATA_W-1:0] dout
);

    logic              rd_acc;
    logic [DATA_W-1:0] rd_val;

    assign rd_acc = !ld_n && !ren_a_n && !ren_b_n;

    // Output process: word presented for the current selection state
    always_comb begin
        unique case (sel)
            SEL_EMPTY_LO: rd_val = DATA_W'(empty_lo);
            SEL_EMPTY_HI: rd_val = DATA_W'(empty_hi);
            SEL_FULL_LO:  rd_val = DATA_W'(full_lo);
            SEL_FULL_HI:  rd_val = DATA_W'(full_hi);
        endcase
    end

    // Read-side share of the selection state and the readback register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps <= 2'd0;
            dout  <= '0;
        end else if (rd_acc) begin
            steps <= steps + 2'd1;
            dout  <= rd_val;
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(dout)); // R4
    AST_RD_HIGH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && sel == SEL_EMPTY_HI) |=> dout[DATA_W-1:HI_W] == '0); // R8

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
    import ofs_bank_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OFS_W  = 14,
    parameter int LO_W   = 8,
    parameter logic [LO_W-1:0] LO_RESET = 'd7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              wen_n,
    input  logic              ren_a_n,
    input  logic              ren_b_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs
);

    localparam int HI_W = OFS_W - LO_W;

    logic [1:0]      wr_steps;
    logic [1:0]      rd_steps;
    logic [1:0]      ptr_sum;
    sel_e            sel;
    logic [LO_W-1:0] lo_q [NUM_OFFSETS];
    logic [HI_W-1:0] hi_q [NUM_OFFSETS];
    logic            din_unused;

    // Selection state register is the pair of step counters; modulo-4 sum
    assign ptr_sum    = wr_steps + rd_steps;
    assign sel        = sel_e'(ptr_sum);
    assign din_unused = ^din;

    ofs_load_port #(
        .DATA_W   (DATA_W),
        .LO_W     (LO_W),
        .HI_W     (HI_W),
        .LO_RESET (LO_RESET)
    ) u_load (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .ld_n  (ld_n),
        .wen_n (wen_n),
        .din   (din),
        .sel   (sel),
        .steps (wr_steps),
        .lo_q  (lo_q),
        .hi_q  (hi_q)
    );

    ofs_read_port #(
        .DATA_W (DATA_W),
        .LO_W   (LO_W),
        .HI_W   (HI_W)
    ) u_read (
        .clk      (rd_clk),
        .rst_n    (rst_n),
        .ld_n     (ld_n),
        .ren_a_n  (ren_a_n),
        .ren_b_n  (ren_b_n),
        .sel      (sel),
        .empty_lo (lo_q[0]),
        .empty_hi (hi_q[0]),
        .full_lo  (lo_q[1]),
        .full_hi  (hi_q[1]),
        .steps    (rd_steps),
        .dout     (dout)
    );

    assign empty_ofs = {hi_q[0], lo_q[0]};
    assign full_ofs  = {hi_q[1], lo_q[1]};

    AST_WRAP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!ld_n && !wen_n && sel == SEL_FULL_HI) |=> sel == SEL_EMPTY_LO); // R7

endmodule

// File: tb/ofs_bank_bench.sv
module ofs_bank_bench;

    localparam logic [2:0] OP_READ = 3'd0;
    localparam logic [2:0] OP_LOAD = 3'd1;
    localparam logic [2:0] OP_REL  = 3'd2;
    localparam logic [2:0] OP_FWR  = 3'd3;
    localparam logic [2:0] OP_NOPL = 3'd4;
    localparam logic [2:0] OP_HALF = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [8:0]  data;
        logic [8:0]  exp_dout;
        logic [13:0] exp_e;
        logic [13:0] exp_f;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{OP_READ, 9'h000, 9'h007, 14'h0007, 14'h0007}, // R1 R4 R6 empty-low default
        '{OP_READ, 9'h000, 9'h000, 14'h0007, 14'h0007}, // R1 empty-high default
        '{OP_READ, 9'h000, 9'h007, 14'h0007, 14'h0007}, // R1 full-low default
        '{OP_READ, 9'h000, 9'h000, 14'h0007, 14'h0007}, // R7 full-high then wrap
        '{OP_LOAD, 9'h1A5, 9'h000, 14'h00A5, 14'h0007}, // R2 R8 bit 8 dropped
        '{OP_REL,  9'h000, 9'h000, 14'h00A5, 14'h0007}, // R5
        '{OP_FWR,  9'h0FF, 9'h000, 14'h00A5, 14'h0007}, // R3 normal FIFO write
        '{OP_NOPL, 9'h033, 9'h000, 14'h00A5, 14'h0007}, // R3 load-mode no-op
        '{OP_LOAD, 9'h1FF, 9'h000, 14'h3FA5, 14'h0007}, // R5 R8 resumes at empty-high
        '{OP_REL,  9'h000, 9'h000, 14'h3FA5, 14'h0007}, // R5
        '{OP_LOAD, 9'h012, 9'h000, 14'h3FA5, 14'h0012}, // R2 full-low
        '{OP_LOAD, 9'h025, 9'h000, 14'h3FA5, 14'h2512}, // R2 R7 full-high then wrap
        '{OP_REL,  9'h000, 9'h000, 14'h3FA5, 14'h2512}, // R5
        '{OP_READ, 9'h000, 9'h0A5, 14'h3FA5, 14'h2512}, // R4
        '{OP_READ, 9'h000, 9'h03F, 14'h3FA5, 14'h2512}, // R4 R8 zero-extended
        '{OP_REL,  9'h000, 9'h03F, 14'h3FA5, 14'h2512}, // R5 R4 hold
        '{OP_READ, 9'h000, 9'h012, 14'h3FA5, 14'h2512}, // R5 resumes at full-low
        '{OP_READ, 9'h000, 9'h025, 14'h3FA5, 14'h2512}, // R4 R7
        '{OP_LOAD, 9'h0C3, 9'h025, 14'h3FC3, 14'h2512}, // R1 shared order
        '{OP_HALF, 9'h000, 9'h025, 14'h3FC3, 14'h2512}, // R4 one enable only
        '{OP_READ, 9'h000, 9'h03F, 14'h3FC3, 14'h2512}  // R4 R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_n = 1'b1;
    logic        wen_n = 1'b1;
    logic        ren_a_n = 1'b1;
    logic        ren_b_n = 1'b1;
    logic [8:0]  din = '0;
    logic [8:0]  dout;
    logic [13:0] empty_ofs;
    logic [13:0] full_ofs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ofs_bank u_ofs_bank (
        .wr_clk    (clk),
        .rd_clk    (clk),
        .rst_n     (rst_n),
        .ld_n      (ld_n),
        .wen_n     (wen_n),
        .ren_a_n   (ren_a_n),
        .ren_b_n   (ren_b_n),
        .din       (din),
        .dout      (dout),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [8:0] d);
        @(negedge clk);
        case (op)
            OP_LOAD: begin ld_n = 1'b0; wen_n = 1'b0; din = d; end
            OP_READ: begin ld_n = 1'b0; ren_a_n = 1'b0; ren_b_n = 1'b0; end
            OP_REL:  begin ld_n = 1'b1; end
            OP_FWR:  begin ld_n = 1'b1; wen_n = 1'b0; din = d; end
            OP_NOPL: begin ld_n = 1'b0; wen_n = 1'b1; din = d; end
            OP_HALF: begin ld_n = 1'b0; ren_a_n = 1'b0; ren_b_n = 1'b1; end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        wen_n = 1'b1;
        ren_a_n = 1'b1;
        ren_b_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6 reset state
        check("R6 empty_ofs in reset", {2'b0, empty_ofs}, 16'h0007);
        check("R6 full_ofs in reset", {2'b0, full_ofs}, 16'h0007);
        check("R6 dout in reset", {7'b0, dout}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].op, VEC[i].data);
            check($sformatf("row %0d dout", i), {7'b0, dout}, {7'b0, VEC[i].exp_dout});
            check($sformatf("row %0d empty_ofs", i), {2'b0, empty_ofs}, {2'b0, VEC[i].exp_e});
            check($sformatf("row %0d full_ofs", i), {2'b0, full_ofs}, {2'b0, VEC[i].exp_f});
        end

        // R6: reset in mid-sequence restores defaults and the first selection
        @(negedge clk);
        ld_n = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R6 empty_ofs after mid reset", {2'b0, empty_ofs}, 16'h0007);
        check("R6 full_ofs after mid reset", {2'b0, full_ofs}, 16'h0007);
        check("R6 dout after mid reset", {7'b0, dout}, 16'h0000);
        rst_n = 1'b1;
        run_op(OP_LOAD, 9'h055);
        check("R6 selection restarts at empty-low", {2'b0, empty_ofs}, 16'h0055);
        check("R6 full untouched after reload", {2'b0, full_ofs}, 16'h0007);
        run_op(OP_READ, 9'h000);
        check("R1 read after load sees empty-high", {7'b0, dout}, 16'h0000);
        run_op(OP_READ, 9'h000);
        check("R1 next read sees full-low", {7'b0, dout}, 16'h0007);

        // R7: loads running over the wrap point
        run_op(OP_LOAD, 9'h1C1);
        check("R8 full-high takes din[5:0]", {2'b0, full_ofs}, 16'h0107);
        run_op(OP_LOAD, 9'h0AA);
        check("R7 wrapped load hits empty-low", {2'b0, empty_ofs}, 16'h00AA);
        run_op(OP_REL, 9'h000);

        finish_run();
    end

endmodule